// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block commits the exception bookkeeping that follows one floating-point arithmetic operation. An operation unit supplies the five IEEE flags it raised, the current 64-bit floating-point status word, and the current and next program counters, all qualified by one strobe. The recorder decides whether the operation traps, reduces the flags to one bit when it traps, rewrites the current-exception and accrued-exception fields, and sets the trap-type field. It then either holds both program counters, so the operation can be re-examined by a handler, or steps them past the operation.

The result is registered on the strobe. In the cycle after the strobe the updated status word and counters are visible, `done_o` pulses, and `trap_o` pulses when the operation traps. A three-state controller sequences the pulses: `ST_IDLE` (no result this cycle), `ST_TRAP` (a trapping result is being presented) and `ST_ADVANCE` (a non-trapping result is being presented). From any state a strobe whose flags hit the enable mask moves to `ST_TRAP`, a strobe whose flags do not moves to `ST_ADVANCE`, and a cycle without a strobe moves to `ST_IDLE`.

Computing the flags and delivering the trap belong to neighbouring logic.

Top module: `fpx_status_recorder`

## Requirements
- R1: While reset is held and right after it, `status_o`, `pc_o` and `npc_o` are zero and `trap_o` and `done_o` are low.
- R2: An update traps exactly when some raised flag is also set in the trap-enable field, status bits 27:23; flag positions inside every 5-bit field are invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0.
- R3: On a trap the current-exception field, status bits 4:0, holds exactly one bit: among the raised flags that are also enabled, the first in the order invalid, overflow, underflow, divide-by-zero, inexact.
- R4: Without a trap the current-exception field is overwritten with the raised flags, whatever it held before.
- R5: The accrued field, status bits 9:5, becomes its old value ORed with the raised flags when there is no trap, and keeps its old value on a trap.
- R6: On a trap the trap-type field, status bits 16:14, is written with 1; without a trap it keeps its old value.
- R7: Without a trap `pc_o` takes the incoming next PC and `npc_o` takes the incoming next PC plus 4 (wrapping at the counter width); on a trap `pc_o` and `npc_o` take the incoming PC and next PC unchanged.
- R8: Every status bit outside the current, accrued and trap-type fields passes through unchanged, the trap-enable field included.
- R9: Results, `done_o` and `trap_o` appear in the cycle after the strobe; `done_o` and `trap_o` last one cycle per strobe, and with no strobe the registered outputs hold their values.
- R10: An update with no raised flags clears the current-exception field, leaves the accrued field unchanged, does not trap and advances the counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_valid_i | input | 1 | Strobe: commit one update this cycle |
| raised_i | input | 5 | IEEE flags raised by the operation |
| status_i | input | 64 | Status word before the update |
| pc_i | input | 64 | Program counter of the operation |
| npc_i | input | 64 | Next program counter |
| status_o | output | 64 | Status word after the update |
| pc_o | output | 64 | Program counter after the update |
| npc_o | output | 64 | Next program counter after the update |
| trap_o | output | 1 | One-cycle pulse: the last update traps |
| done_o | output | 1 | One-cycle pulse: a result is presented |

## Verification
Every result of this block, the status word, both counters and the two pulses, is due exactly one rising edge after the strobe. The bench changes inputs on the falling edge, raises the strobe for one cycle, and compares all outputs on the following falling edge, after the capturing rising edge has settled them. For a subset of updates it waits one more falling edge to confirm that the pulses have dropped and the registered values have held, and one directed pair of back-to-back strobes checks that each result appears in its own cycle.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int FLAG_W = 5;

    localparam int FLG_INVALID   = 4;
    localparam int FLG_OVERFLOW  = 3;
    localparam int FLG_UNDERFLOW = 2;
    localparam int FLG_DIVZERO   = 1;
    localparam int FLG_INEXACT   = 0;

    // Trap reduction order, most important first.
    localparam int PRIO_ORDER [FLAG_W] = '{FLG_INVALID, FLG_OVERFLOW,
                                            FLG_UNDERFLOW, FLG_DIVZERO,
                                            FLG_INEXACT};

    typedef logic [FLAG_W-1:0] fpx_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TRAP    = 2'd1,
        ST_ADVANCE = 2'd2
    } fpx_state_e;

endpackage

// File: rtl/fpx_trap_decide.sv
module fpx_trap_decide
    import fpx_pkg::*;
(
    input  fpx_flags_t raised_i,
    input  fpx_flags_t enable_i,
    output logic       trap_o,
    output fpx_flags_t cur_o
);

    fpx_flags_t hit;
    fpx_flags_t single;

    assign hit    = raised_i & enable_i;
    assign trap_o = |hit;

    always_comb begin
        single = '0;
        for (int k = FLAG_W - 1; k >= 0; k--) begin
            if (hit[PRIO_ORDER[k]]) begin
                single = '0;
                single[PRIO_ORDER[k]] = 1'b1;
            end
        end
    end

    assign cur_o = trap_o ? single : raised_i;

    // R3: a trap keeps one flag only, and it came from the raised set
    always_comb begin
        a_r3_single_kept: assert (!trap_o || ($countones(cur_o) == 1 && (cur_o & ~raised_i) == '0));
    end

endmodule

// File: rtl/fpx_status_merge.sv
module fpx_status_merge
    import fpx_pkg::*;
#(
    parameter int STAT_W  = 64,
    parameter int ACC_LSB = 5,
    parameter int CUR_LSB = 0,
    parameter int TT_LSB  = 14,
    parameter int TT_W    = 3,
    parameter int TT_IEEE = 1
) (
    input  logic [STAT_W-1:0] status_i,
    input  fpx_flags_t        raised_i,
    input  fpx_flags_t        cur_i,
    input  logic              trap_i,
    output logic [STAT_W-1:0] status_o
);

    localparam logic [TT_W-1:0] TT_CODE = TT_W'(TT_IEEE);

    always_comb begin
        status_o = status_i;
        status_o[CUR_LSB +: FLAG_W] = cur_i;
        if (trap_i) begin
            status_o[TT_LSB +: TT_W] = TT_CODE;
        end else begin
            status_o[ACC_LSB +: FLAG_W] = status_i[ACC_LSB +: FLAG_W] | raised_i;
        end
    end

endmodule

// File: rtl/fpx_pc_step.sv
module fpx_pc_step #(
    parameter int PC_W    = 64,
    parameter int PC_STEP = 4
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] npc_i,
    input  logic            trap_i,
    output logic [PC_W-1:0] pc_o,
    output logic [PC_W-1:0] npc_o
);

    localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

    always_comb begin
        if (trap_i) begin
            pc_o  = pc_i;
            npc_o = npc_i;
        end else begin
            pc_o  = npc_i;
            npc_o = npc_i + STEP_V;
        end
    end

endmodule

// File: rtl/fpx_status_recorder.sv
module fpx_status_recorder
    import fpx_pkg::*;
#(
    parameter int STAT_W  = 64,
    parameter int PC_W    = 64,
    parameter int PC_STEP = 4,
    parameter int ENA_LSB = 23,
    parameter int ACC_LSB = 5,
    parameter int CUR_LSB = 0,
    parameter int TT_LSB  = 14,
    parameter int TT_W    = 3,
    parameter int TT_IEEE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid_i,
    input  logic [4:0]        raised_i,
    input  logic [STAT_W-1:0] status_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   npc_i,
    output logic [STAT_W-1:0] status_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [PC_W-1:0]   npc_o,
    output logic              trap_o,
    output logic              done_o
);

    localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

    fpx_flags_t        enable;
    fpx_flags_t        cur_flags;
    logic              trap_now;
    logic [STAT_W-1:0] status_next;
    logic [PC_W-1:0]   pc_next;
    logic [PC_W-1:0]   npc_next;

    fpx_state_e state_q;
    fpx_state_e state_d;

    assign enable = status_i[ENA_LSB +: FLAG_W];

    fpx_trap_decide u_decide (
        .raised_i (raised_i),
        .enable_i (enable),
        .trap_o   (trap_now),
        .cur_o    (cur_flags)
    );

    fpx_status_merge #(
        .STAT_W  (STAT_W),
        .ACC_LSB (ACC_LSB),
        .CUR_LSB (CUR_LSB),
        .TT_LSB  (TT_LSB),
        .TT_W    (TT_W),
        .TT_IEEE (TT_IEEE)
    ) u_merge (
        .status_i (status_i),
        .raised_i (raised_i),
        .cur_i    (cur_flags),
        .trap_i   (trap_now),
        .status_o (status_next)
    );

    fpx_pc_step #(
        .PC_W    (PC_W),
        .PC_STEP (PC_STEP)
    ) u_pc (
        .pc_i   (pc_i),
        .npc_i  (npc_i),
        .trap_i (trap_now),
        .pc_o   (pc_next),
        .npc_o  (npc_next)
    );

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_TRAP, ST_ADVANCE: begin
                if (upd_valid_i) begin
                    state_d = trap_now ? ST_TRAP : ST_ADVANCE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        trap_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    begin trap_o = 1'b0; done_o = 1'b0; end
            ST_TRAP:    begin trap_o = 1'b1; done_o = 1'b1; end
            ST_ADVANCE: begin trap_o = 1'b0; done_o = 1'b1; end
            default:    begin trap_o = 1'b0; done_o = 1'b0; end
        endcase
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_o <= '0;
            pc_o     <= '0;
            npc_o    <= '0;
        end else if (upd_valid_i) begin
            status_o <= status_next;
            pc_o     <= pc_next;
            npc_o    <= npc_next;
        end
    end

    // R2: trap pulse follows the enabled flags of the previous strobe
    a_r2_trap_matches_enable: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (trap_o == (|($past(raised_i) & $past(status_i[ENA_LSB +: FLAG_W])))));

    // R3: a trapping result carries one current bit
    a_r3_one_current_bit: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> ($countones(status_o[CUR_LSB +: FLAG_W]) == 1));

    // R5: accrued field untouched by a trap
    a_r5_accrued_held_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (status_o[ACC_LSB +: FLAG_W] == $past(status_i[ACC_LSB +: FLAG_W])));

    // R7: counters step on a non-trapping result
    a_r7_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !trap_o) |-> (pc_o == $past(npc_i) && npc_o == $past(npc_i) + STEP_V));

    // R7: counters held on a trapping result
    a_r7_pc_hold_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (pc_o == $past(pc_i) && npc_o == $past(npc_i)));

    // R9: no strobe, no pulse and no change
    a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid_i |=> (!done_o && $stable(status_o) && $stable(pc_o) && $stable(npc_o)));

    // R9: trap pulse only with a result
    a_r9_trap_within_done: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> done_o);

endmodule

// File: tb/sim_fpx_status_recorder.sv
module sim_fpx_status_recorder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid_i = 1'b0;
    logic [4:0]  raised_i = '0;
    logic [63:0] status_i = '0;
    logic [63:0] pc_i = '0;
    logic [63:0] npc_i = '0;
    logic [63:0] status_o;
    logic [63:0] pc_o;
    logic [63:0] npc_o;
    logic        trap_o;
    logic        done_o;

    int nchecks = 0;
    int nfail   = 0;

    always #5ns clk = ~clk;

    fpx_status_recorder u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_valid_i (upd_valid_i),
        .raised_i    (raised_i),
        .status_i    (status_i),
        .pc_i        (pc_i),
        .npc_i       (npc_i),
        .status_o    (status_o),
        .pc_o        (pc_o),
        .npc_o       (npc_o),
        .trap_o      (trap_o),
        .done_o      (done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements
    task automatic model(input logic [4:0] fl, input logic [63:0] st, input logic [63:0] pc,
                         input logic [63:0] npc, output logic [63:0] e_st,
                         output logic [63:0] e_pc, output logic [63:0] e_npc, output bit e_trap);
        logic [4:0] hit;
        logic [4:0] one;
        hit = fl & st[27:23];
        e_trap = (hit != 0);
        one = 5'b0;
        if      (hit[4]) one = 5'b10000;
        else if (hit[3]) one = 5'b01000;
        else if (hit[2]) one = 5'b00100;
        else if (hit[1]) one = 5'b00010;
        else if (hit[0]) one = 5'b00001;
        e_st = st;
        if (e_trap) begin
            e_st[4:0]   = one;
            e_st[16:14] = 3'd1;
            e_pc  = pc;
            e_npc = npc;
        end else begin
            e_st[4:0] = fl;
            e_st[9:5] = st[9:5] | fl;
            e_pc  = npc;
            e_npc = npc + 64'd4;
        end
    endtask

    task automatic drive(input logic [4:0] fl, input logic [63:0] st, input logic [63:0] pc, input logic [63:0] npc);
        raised_i    = fl;
        status_i    = st;
        pc_i        = pc;
        npc_i       = npc;
        upd_valid_i = 1'b1;
    endtask

    task automatic compare(input logic [4:0] fl, input logic [63:0] st, input logic [63:0] pc,
                           input logic [63:0] npc, input string cur_tag);
        logic [63:0] e_st, e_pc, e_npc;
        bit e_trap;
        logic [63:0] mask_other;
        model(fl, st, pc, npc, e_st, e_pc, e_npc, e_trap);
        mask_other = ~64'h1_C3FF;
        chk(trap_o == e_trap, "R2 trap", 64'(trap_o), 64'(e_trap));
        chk(status_o[4:0] == e_st[4:0], cur_tag, 64'(status_o[4:0]), 64'(e_st[4:0]));
        chk(status_o[9:5] == e_st[9:5], "R5 accrued", 64'(status_o[9:5]), 64'(e_st[9:5]));
        chk(status_o[16:14] == e_st[16:14], "R6 trap type", 64'(status_o[16:14]), 64'(e_st[16:14]));
        chk((status_o & mask_other) == (e_st & mask_other), "R8 other bits", status_o, e_st);
        chk(pc_o == e_pc, "R7 pc", pc_o, e_pc);
        chk(npc_o == e_npc, "R7 npc", npc_o, e_npc);
        chk(done_o == 1'b1, "R9 done pulse", 64'(done_o), 64'd1);
    endtask

    // One strobe, result checked one edge later, optional hold check
    task automatic one_update(input logic [4:0] fl, input logic [63:0] st, input logic [63:0] pc,
                              input logic [63:0] npc, input string cur_tag, input bit hold_chk);
        logic [63:0] s_keep;
        @(negedge clk);
        drive(fl, st, pc, npc);
        @(negedge clk);
        upd_valid_i = 1'b0;
        compare(fl, st, pc, npc, cur_tag);
        if (hold_chk) begin
            s_keep = status_o;
            raised_i = ~fl;
            status_i = ~st;
            @(negedge clk);
            chk(done_o == 1'b0 && trap_o == 1'b0, "R9 pulse drops", {62'b0, done_o, trap_o}, 64'd0);
            chk(status_o == s_keep, "R9 hold", status_o, s_keep);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin : main
        logic [63:0] st;
        logic [4:0]  fl;
        void'($urandom(32'd7215));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(status_o == 64'd0, "R1 status", status_o, 64'd0);
        chk(pc_o == 64'd0 && npc_o == 64'd0, "R1 pc", pc_o | npc_o, 64'd0);
        chk(trap_o == 1'b0 && done_o == 1'b0, "R1 pulses", {62'b0, trap_o, done_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 1'b0 && status_o == 64'd0, "R1 after release", status_o, 64'd0);

        // R3 all raised, all enabled: invalid wins
        one_update(5'h1F, 64'h0F80_0000 | (64'd7 << 14) | 64'h3E0, 64'h100, 64'h104, "R3 priority", 1'b1);
        // R3 overflow+inexact raised, only inexact enabled
        one_update(5'b01001, 64'd1 << 23, 64'h200, 64'h204, "R3 masked", 1'b1);
        // R3 underflow+divzero both enabled: underflow wins
        one_update(5'b00110, 64'h0F80_0000, 64'h300, 64'h304, "R3 order", 1'b0);
        // R4/R5 all raised, none enabled, old current bits set
        one_update(5'h1F, 64'hA5A5_0000_0000_0000 | (64'd5 << 14) | 64'h1B, 64'h400, 64'h404, "R4 overwrite", 1'b1);
        // R6 no trap keeps trap-type 5
        one_update(5'b00001, (64'd5 << 14) | (64'h10 << 23), 64'h500, 64'h504, "R4 partial", 1'b0);
        // R10 zero flags with full current and accrued
        one_update(5'd0, 64'h0F80_0000 | 64'h3FF, 64'h600, 64'h604, "R10 zero flags", 1'b1);
        // R7 wrap of next counter
        one_update(5'd2, 64'd0, 64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFFC, "R7 wrap", 1'b0);

        // R9 back-to-back strobes: trap then advance
        @(negedge clk);
        drive(5'b10000, 64'd1 << 27, 64'h700, 64'h704);
        @(negedge clk);
        compare(5'b10000, 64'd1 << 27, 64'h700, 64'h704, "R9 first of pair");
        drive(5'b10000, 64'd1 << 26, 64'h800, 64'h804);
        @(negedge clk);
        upd_valid_i = 1'b0;
        compare(5'b10000, 64'd1 << 26, 64'h800, 64'h804, "R9 second of pair");

        // Random updates
        for (int i = 0; i < 400; i++) begin
            st = {$urandom, $urandom};
            if ($urandom % 3 == 0) st[27:23] = 5'd0;
            fl = 5'($urandom);
            if ($urandom % 8 == 0) fl = 5'd0;
            one_update(fl, st, {$urandom, $urandom}, {$urandom, $urandom},
                       (fl == 0) ? "R10 random zero" : "R3 R4 random current", (i % 4) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

endmodule